// File: doc/BRIEF.md
# Event Status Interrupt Register Bank

This block carries event notifications from a firmware agent to a driver agent through three 16-bit registers. Firmware raises events by pulsing bits of a 16-bit set strobe. Each pulsed bit latches into a pending register, where it stays until the driver acknowledges it. The driver reaches all three registers through a small indexed port with a 7-bit index, 16-bit write data, a write strobe and combinational read data.

Two separate masks act on the same pending register, and each drives its own output. A report-enable register selects which pending events raise the aggregated event flag. That flag is meant to feed one status bit of a serial frame. A wake-mask register selects which pending events raise the interrupt/wakeup line. Both outputs are registered, so each follows a register change by exactly one clock.

The driver acknowledges an event by writing zero to its bit in the pending register. A one written to a bit leaves that bit alone. This lets the driver clear a chosen subset of events in one write without disturbing the rest. A firmware set in the same cycle as a driver clear wins.

Top module: `evbank_top`

## Requirements
- R1: After reset the report-enable, wake-mask and pending registers all read 0000h, and `event_flag` and `irq_wake` are 0.
- R2: The report-enable register at index 70h and the wake-mask register at index 72h are plain read/write 16-bit registers: a write updates them on the clock edge and a read returns the stored value.
- R3: A 1 on bit i of `fw_set` at a clock edge sets bit i of the pending register (index 7Ah). The bit stays set until the driver clears it, and no pending bit becomes set without a strobe.
- R4: A write to index 7Ah clears every pending bit whose write-data bit is 0 and leaves unchanged every pending bit whose write-data bit is 1.
- R5: When `fw_set` bit i and a clearing write to bit i of index 7Ah occur on the same edge, pending bit i ends up set.
- R6: `event_flag` equals the OR over all 16 bits of (pending AND report-enable), and it updates one clock after the register change that causes it.
- R7: `irq_wake` equals the OR over all 16 bits of (pending AND wake-mask), and it updates one clock after the register change that causes it. The report-enable register has no effect on it, and the wake-mask register has no effect on `event_flag`.
- R8: A read at any index other than 70h, 72h or 7Ah returns 0000h, and a write to any such index changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fw_set | input | 16 | Firmware event set strobe, one bit per event |
| reg_idx | input | 7 | Register index for driver access |
| reg_wdata | input | 16 | Driver write data |
| reg_we | input | 1 | Driver write strobe |
| reg_rdata | output | 16 | Read data for `reg_idx` (combinational) |
| event_flag | output | 1 | Aggregated reported-event flag |
| irq_wake | output | 1 | Interrupt/wakeup request |

## Verification
The main function is driven with a table of report-enable, wake-mask, set and clear patterns. One group of patterns places pending bits only under one mask, which tells apart the two output paths. Others use alternating and split bit patterns, so that a clear that ignores its write data, or acts on the wrong half of the word, leaves a visibly wrong pending value. Directed cases cover the reset values, the one-clock output latency, set-over-clear priority on a shared bit, and a write to an unused index.

// File: rtl/evbank_pkg.sv
package evbank_pkg;
    localparam int EV_W  = 16;
    localparam int IDX_W = 7;

    localparam logic [IDX_W-1:0] IDX_REPORT_EN = 7'h70;
    localparam logic [IDX_W-1:0] IDX_WAKE_MASK = 7'h72;
    localparam logic [IDX_W-1:0] IDX_PENDING   = 7'h7A;
endpackage

// File: rtl/evbank_cfg_reg.sv
module evbank_cfg_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else if (wr_i) q_o <= wdata_i;
    end

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> q_o == $past(wdata_i)); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(q_o)); // R8
endmodule

// File: rtl/evbank_pending.sv
module evbank_pending #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] clr_mask;
    logic [W-1:0] q_next;

    assign clr_mask = wr_i ? ~wdata_i : '0;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // set has priority over a same-cycle clear
        assign q_next[b] = set_i[b] | (q_o[b] & ~clr_mask[b]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else q_o <= q_next;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i))); // R5
    AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q_o & ~$past(q_o) & ~$past(set_i)) == '0)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && set_i == '0) |=> $stable(q_o)); // R4
endmodule

// File: rtl/evbank_reduce.sv
module evbank_reduce #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vec_i,
    input  logic [W-1:0] mask_i,
    output logic         flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_o <= 1'b0;
        else flag_o <= |(vec_i & mask_i);
    end

    AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((vec_i & mask_i) == '0) |=> !flag_o); // R6
    AST_ROSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> ($past(vec_i & mask_i) != '0)); // R7
endmodule

// File: rtl/evbank_top.sv
module evbank_top
    import evbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EV_W-1:0]  fw_set,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [EV_W-1:0]  reg_wdata,
    input  logic             reg_we,
    output logic [EV_W-1:0]  reg_rdata,
    output logic             event_flag,
    output logic             irq_wake
);
    logic wr_en_reg, wr_mask_reg, wr_pend_reg;
    logic [EV_W-1:0] report_en, wake_mask, pending;

    assign wr_en_reg   = reg_we && (reg_idx == IDX_REPORT_EN);
    assign wr_mask_reg = reg_we && (reg_idx == IDX_WAKE_MASK);
    assign wr_pend_reg = reg_we && (reg_idx == IDX_PENDING);

    evbank_cfg_reg #(.W(EV_W)) u_report_en (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_en_reg),
        .wdata_i(reg_wdata), .q_o(report_en));

    evbank_cfg_reg #(.W(EV_W)) u_wake_mask (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_mask_reg),
        .wdata_i(reg_wdata), .q_o(wake_mask));

    evbank_pending #(.W(EV_W)) u_pending (
        .clk(clk), .rst_n(rst_n), .set_i(fw_set), .wr_i(wr_pend_reg),
        .wdata_i(reg_wdata), .q_o(pending));

    evbank_reduce #(.W(EV_W)) u_flag (
        .clk(clk), .rst_n(rst_n), .vec_i(pending),
        .mask_i(report_en), .flag_o(event_flag));

    evbank_reduce #(.W(EV_W)) u_wake (
        .clk(clk), .rst_n(rst_n), .vec_i(pending),
        .mask_i(wake_mask), .flag_o(irq_wake));

    always_comb begin
        case (reg_idx)
            IDX_REPORT_EN: reg_rdata = report_en;
            IDX_WAKE_MASK: reg_rdata = wake_mask;
            IDX_PENDING:   reg_rdata = pending;
            default:       reg_rdata = '0;
        endcase
    end

    AST_RDATA_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx != IDX_REPORT_EN && reg_idx != IDX_WAKE_MASK &&
         reg_idx != IDX_PENDING) |-> reg_rdata == '0); // R8
    AST_OUT_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |=> (!event_flag && !irq_wake)); // R1
endmodule

// File: tb/tb_evbank_top.sv
`timescale 1ns/1ps
module tb_evbank_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fw_set = '0;
    logic [6:0]  reg_idx = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_rdata;
    logic        event_flag, irq_wake;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    evbank_top dut (
        .clk(clk), .rst_n(rst_n), .fw_set(fw_set), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .event_flag(event_flag), .irq_wake(irq_wake));

    // columns: report-enable, wake-mask, set pattern, clear write
    localparam logic [63:0] VEC [8] = '{
        {16'hFFFF, 16'h0000, 16'h0001, 16'hFFFF},
        {16'h0000, 16'hFFFF, 16'h8000, 16'hFFFF},
        {16'h00F0, 16'h0F00, 16'h0FF0, 16'hFFFF},
        {16'h00F0, 16'h0F00, 16'h0F0F, 16'hFFFF},
        {16'hFFFF, 16'hFFFF, 16'hA5A5, 16'h5A5A},
        {16'hFFFF, 16'hFFFF, 16'hA5A5, 16'hFF00},
        {16'h0001, 16'h0002, 16'h0003, 16'hFFFE},
        {16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] idx, input logic [15:0] d);
        @(negedge clk);
        reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] s);
        @(negedge clk);
        fw_set = s;
        @(posedge clk);
        @(negedge clk);
        fw_set = '0;
    endtask

    task automatic rd(input logic [6:0] idx, output logic [15:0] d);
        reg_idx = idx;
        #0.5;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        rd(7'h70, r); chk("R1 enable", r, 16'h0000);
        rd(7'h72, r); chk("R1 mask", r, 16'h0000);
        rd(7'h7A, r); chk("R1 pending", r, 16'h0000);
        chk("R1 outputs", {14'd0, event_flag, irq_wake}, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            logic [15:0] en, mk, st, cl, ep;
            {en, mk, st, cl} = VEC[i];
            ep = st & cl;
            wr(7'h70, en);
            wr(7'h72, mk);
            wr(7'h7A, 16'h0000);
            pulse(st);
            wr(7'h7A, cl);
            @(posedge clk); @(negedge clk);
            rd(7'h7A, r); chk("R3/R4 pending after clear", r, ep);
            chk("R6 event_flag", {15'd0, event_flag}, {15'd0, |(ep & en)});
            chk("R7 irq_wake", {15'd0, irq_wake}, {15'd0, |(ep & mk)});
            rd(7'h70, r); chk("R2 enable readback", r, en);
            rd(7'h72, r); chk("R2 mask readback", r, mk);
        end

        // R6 latency: flag rises one clock after the pending bit
        wr(7'h7A, 16'h0000);
        wr(7'h70, 16'h0010);
        wr(7'h72, 16'h0000);
        @(posedge clk); @(negedge clk);
        pulse(16'h0010);
        chk("R6 flag not yet", {15'd0, event_flag}, 16'h0000);
        @(posedge clk); @(negedge clk);
        chk("R6 flag after one clock", {15'd0, event_flag}, 16'h0001);
        chk("R7 mask off irq", {15'd0, irq_wake}, 16'h0000);

        // R5 set wins over same-cycle clear
        wr(7'h7A, 16'h0000);
        @(negedge clk);
        fw_set = 16'h0404;
        reg_idx = 7'h7A; reg_wdata = 16'hFBFF; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        fw_set = '0; reg_we = 1'b0;
        rd(7'h7A, r); chk("R5 set beats clear", r, 16'h0404);

        // R4 writing ones leaves bits intact
        wr(7'h7A, 16'hFFFF);
        rd(7'h7A, r); chk("R4 write ones no change", r, 16'h0404);

        // R8 unused index
        wr(7'h71, 16'hFFFF);
        rd(7'h71, r); chk("R8 unused read", r, 16'h0000);
        rd(7'h70, r); chk("R8 enable untouched", r, 16'h0010);
        rd(7'h72, r); chk("R8 mask untouched", r, 16'h0000);
        rd(7'h7A, r); chk("R8 pending untouched", r, 16'h0404);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule